// File: doc/BRIEF.md
# Automated Teller Transaction Controller

This block is the sequencing core of a small automated teller. It takes an 8-bit switch bus and five button pulses, each one clock wide and already debounced. It holds the account balance and the stored PIN in registers, and it drives four display digits, a blink flag and an error flag. A downstream display driver multiplexes these onto seven-segment digits.

A session begins with PIN entry. Once the PIN is accepted, a cyclic menu offers five services: balance inquiry, cash withdrawal, cash deposit, check deposit and PIN change. Cash amounts are built one denomination per press. An accepted amount stays on the display with blinking for a fixed hold interval, and the updated balance follows. The balance cap, the withdrawal limits and PIN reuse are each rejected with their own four-digit error code. Enter clears the error.

Top module: `atm_ctrl`

## Requirements
- R1: After synchronous reset the block is in PIN entry. The balance is 0 and the stored PIN is `PIN_INIT` (0x5A). `digits` shows `{8'h00, sw}`, and `blink` and `err` are low.
- R2: In PIN entry, enter with `sw` equal to the stored PIN opens the menu with service 1 selected. Any other value gives error code 0xE005, and enter then returns to PIN entry.
- R3: The menu shows the selected service number 1 to 5 as `{12'h000, n}` (1 balance, 2 withdrawal, 3 cash deposit, 4 check deposit, 5 PIN change). Up or right moves forward and down or left moves back, both wrapping between 5 and 1. Enter opens the selected service with the amount cleared.
- R4: In withdrawal and cash deposit, up adds 10, right adds 20, down adds 50 and left adds 100 to an amount that starts at 0 and is shown as four BCD digits. A press that would take the amount above 9999 is ignored.
- R5: On enter, a withdrawal whose amount is not a multiple of 20 or is above 500 gives 0xE001. Otherwise, an amount above the balance gives 0xE002. Otherwise the amount is subtracted from the balance.
- R6: On enter, a cash deposit that would take the balance above 1500 gives 0xE003 and leaves the balance unchanged. Otherwise the amount is added.
- R7: Check deposit reads `sw[7:4]` as the tens digit and `sw[3:0]` as the units digit, and shows `{8'h00, sw}`. On enter, a nibble above 9 gives 0xE001, and a result above 1500 gives 0xE003. Otherwise the value is added to the balance.
- R8: An accepted amount is shown for `HOLD_CYCLES` cycles. `blink` is high for the first `TOGGLE_CYCLES` cycles and then alternates with that period, and buttons are ignored during this time. Afterwards the balance is shown with `blink` low until enter returns to the menu.
- R9: Balance inquiry shows the balance as BCD, and enter returns to the menu.
- R10: PIN change shows `{8'h00, sw}`. Enter with `sw` equal to the stored PIN gives 0xE004 and keeps the PIN. Any other value replaces the PIN and returns to the menu.
- R11: While an error is shown, `err` is high and `digits` is `{4'hE, 8'h00, code}`. Enter returns to the menu, except for code 5, which returns to PIN entry. `err` is low in every other state.
- R12: The balance never exceeds 1500. It changes only in a cycle where enter accepts a transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (100 MHz nominal) |
| rst | input | 1 | Synchronous reset, active high |
| sw | input | 8 | Switch bus: PIN or BCD check value |
| btn_up | input | 1 | Up pulse: next service / add 10 |
| btn_down | input | 1 | Down pulse: previous service / add 50 |
| btn_left | input | 1 | Left pulse: previous service / add 100 |
| btn_right | input | 1 | Right pulse: next service / add 20 |
| btn_enter | input | 1 | Enter pulse: confirm |
| digits | output | 16 | Four hex/BCD digit codes, most significant first |
| blink | output | 1 | Display blink enable |
| err | output | 1 | High while an error code is shown |

## Verification
The hardest state to reach is the amount ceiling at 9999. It takes about a hundred denomination presses, and it only matters in combination with the deposit cap check that follows. The stimulus drives a long burst of 100-unit presses, then probes the ignore rule with 100 and 50 presses at the boundary before confirming. The other hard case is proving that a PIN change took effect, because the stored PIN cannot be read. The bench attempts a second change with the same value and expects the reuse error. The hold interval is shortened through parameters so that the blink phases and the exact exit cycle are compared on every clock.

// File: rtl/atm_pkg.sv
package atm_pkg;
    typedef enum logic [3:0] {
        ST_PIN, ST_MENU, ST_BAL, ST_WDR, ST_DEP, ST_CHK,
        ST_NEWPIN, ST_HOLD, ST_RESULT, ST_ERR
    } atm_state_e;

    localparam logic [3:0] CODE_BADAMT  = 4'd1;
    localparam logic [3:0] CODE_NOFUNDS = 4'd2;
    localparam logic [3:0] CODE_CAP     = 4'd3;
    localparam logic [3:0] CODE_SAMEPIN = 4'd4;
    localparam logic [3:0] CODE_BADPIN  = 4'd5;
endpackage

// File: rtl/atm_bcd.sv
module atm_bcd #(
    parameter int unsigned BIN_W  = 14,
    parameter int unsigned DIGITS = 4
) (
    input  logic [BIN_W-1:0]    bin,
    output logic [4*DIGITS-1:0] bcd
);
    localparam int unsigned SH_W = 4*DIGITS + BIN_W;

    always_comb begin
        logic [SH_W-1:0] sh_d;
        sh_d = {{(4*DIGITS){1'b0}}, bin};
        for (int i = 0; i < BIN_W; i++) begin
            for (int d = 0; d < DIGITS; d++) begin
                if (sh_d[BIN_W + 4*d +: 4] >= 4'd5)
                    sh_d[BIN_W + 4*d +: 4] = sh_d[BIN_W + 4*d +: 4] + 4'd3;
            end
            sh_d = sh_d << 1;
        end
        bcd = sh_d[BIN_W +: 4*DIGITS];
    end
endmodule

// File: rtl/atm_hold_timer.sv
module atm_hold_timer #(
    parameter int unsigned HOLD_CYCLES   = 500_000_000,
    parameter int unsigned TOGGLE_CYCLES = 50_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic done,
    output logic lit
);
    localparam int unsigned HW = (HOLD_CYCLES > 1) ? $clog2(HOLD_CYCLES) : 1;
    localparam int unsigned TW = (TOGGLE_CYCLES > 1) ? $clog2(TOGGLE_CYCLES) : 1;

    typedef struct packed {
        logic [HW-1:0] cnt;
        logic [TW-1:0] tog;
        logic          ph;
    } tmr_t;

    tmr_t tmr_q, tmr_d;

    always_comb begin
        tmr_d = tmr_q;
        if (!run) begin
            tmr_d = '0;
        end else begin
            tmr_d.cnt = tmr_q.cnt + 1'b1;
            if (tmr_q.tog == TW'(TOGGLE_CYCLES - 1)) begin
                tmr_d.tog = '0;
                tmr_d.ph  = ~tmr_q.ph;
            end else begin
                tmr_d.tog = tmr_q.tog + 1'b1;
            end
        end
        done = run && (tmr_q.cnt == HW'(HOLD_CYCLES - 1));
        lit  = run && !tmr_q.ph;
    end

    always_ff @(posedge clk) begin
        if (rst) tmr_q <= '0;
        else     tmr_q <= tmr_d;
    end
endmodule

// File: rtl/atm_ctrl.sv
module atm_ctrl
    import atm_pkg::*;
#(
    parameter int unsigned HOLD_CYCLES   = 500_000_000,
    parameter int unsigned TOGGLE_CYCLES = 50_000_000,
    parameter int unsigned BAL_W         = 12,
    parameter int unsigned AMT_W         = 14,
    parameter int unsigned DIGITS        = 4,
    parameter int unsigned BAL_MAX       = 1500,
    parameter int unsigned WDR_MAX       = 500,
    parameter int unsigned WDR_STEP      = 20,
    parameter int unsigned AMT_LIM       = 9999,
    parameter int unsigned DEN_UP        = 10,
    parameter int unsigned DEN_RIGHT     = 20,
    parameter int unsigned DEN_DOWN      = 50,
    parameter int unsigned DEN_LEFT      = 100,
    parameter logic [7:0]  PIN_INIT      = 8'h5A
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [7:0]            sw,
    input  logic                  btn_up,
    input  logic                  btn_down,
    input  logic                  btn_left,
    input  logic                  btn_right,
    input  logic                  btn_enter,
    output logic [4*DIGITS-1:0]   digits,
    output logic                  blink,
    output logic                  err
);
    localparam int unsigned DW    = 4*DIGITS;
    localparam int unsigned SUM_W = AMT_W + 1;
    localparam logic [SUM_W-1:0] LIM_S  = SUM_W'(AMT_LIM);
    localparam logic [SUM_W-1:0] CAP_S  = SUM_W'(BAL_MAX);
    localparam logic [SUM_W-1:0] WMAX_S = SUM_W'(WDR_MAX);
    localparam logic [2:0]       SEL_LAST = 3'd4;

    typedef struct packed {
        atm_state_e       state;
        logic [2:0]       sel;
        logic [AMT_W-1:0] amt;
        logic [BAL_W-1:0] bal;
        logic [7:0]       pin;
        logic [3:0]       code;
        logic             to_pin;
    } regs_t;

    regs_t cur_q, nxt_d;

    logic             hold_done, hold_lit;
    logic             den_hit;
    logic [SUM_W-1:0] den_val, amt_ext, bal_ext, amt_sum, dep_sum, chk_val, chk_sum;
    logic             wdr_bad, nib_bad;
    logic             show_raw;
    logic [DW-1:0]    raw_val, bcd_val;
    logic [AMT_W-1:0] num_val;

    atm_hold_timer #(
        .HOLD_CYCLES  (HOLD_CYCLES),
        .TOGGLE_CYCLES(TOGGLE_CYCLES)
    ) u_hold (
        .clk (clk),
        .rst (rst),
        .run (cur_q.state == ST_HOLD),
        .done(hold_done),
        .lit (hold_lit)
    );

    atm_bcd #(
        .BIN_W (AMT_W),
        .DIGITS(DIGITS)
    ) u_bcd (
        .bin(num_val),
        .bcd(bcd_val)
    );

    // Arithmetic shared by the service states
    always_comb begin
        den_hit = btn_up | btn_right | btn_down | btn_left;
        if (btn_up)         den_val = SUM_W'(DEN_UP);
        else if (btn_right) den_val = SUM_W'(DEN_RIGHT);
        else if (btn_down)  den_val = SUM_W'(DEN_DOWN);
        else                den_val = SUM_W'(DEN_LEFT);
        amt_ext = SUM_W'(cur_q.amt);
        bal_ext = SUM_W'(cur_q.bal);
        amt_sum = amt_ext + den_val;
        dep_sum = bal_ext + amt_ext;
        wdr_bad = ((amt_ext % SUM_W'(WDR_STEP)) != '0) || (amt_ext > WMAX_S);
        nib_bad = (sw[7:4] > 4'd9) || (sw[3:0] > 4'd9);
        chk_val = SUM_W'(sw[7:4]) * SUM_W'(10) + SUM_W'(sw[3:0]);
        chk_sum = bal_ext + chk_val;
    end

    // Next-state logic
    always_comb begin
        nxt_d = cur_q;
        unique case (cur_q.state)
            ST_PIN: begin
                if (btn_enter) begin
                    if (sw == cur_q.pin) begin
                        nxt_d.state = ST_MENU;
                        nxt_d.sel   = '0;
                    end else begin
                        nxt_d.state  = ST_ERR;
                        nxt_d.code   = CODE_BADPIN;
                        nxt_d.to_pin = 1'b1;
                    end
                end
            end
            ST_MENU: begin
                if (btn_enter) begin
                    nxt_d.amt = '0;
                    case (cur_q.sel)
                        3'd0:    nxt_d.state = ST_BAL;
                        3'd1:    nxt_d.state = ST_WDR;
                        3'd2:    nxt_d.state = ST_DEP;
                        3'd3:    nxt_d.state = ST_CHK;
                        default: nxt_d.state = ST_NEWPIN;
                    endcase
                end else if (btn_up || btn_right) begin
                    nxt_d.sel = (cur_q.sel == SEL_LAST) ? 3'd0 : cur_q.sel + 3'd1;
                end else if (btn_down || btn_left) begin
                    nxt_d.sel = (cur_q.sel == 3'd0) ? SEL_LAST : cur_q.sel - 3'd1;
                end
            end
            ST_BAL, ST_RESULT: begin
                if (btn_enter) nxt_d.state = ST_MENU;
            end
            ST_WDR: begin
                if (btn_enter) begin
                    if (wdr_bad) begin
                        nxt_d.state  = ST_ERR;
                        nxt_d.code   = CODE_BADAMT;
                        nxt_d.to_pin = 1'b0;
                        nxt_d.amt    = '0;
                    end else if (amt_ext > bal_ext) begin
                        nxt_d.state  = ST_ERR;
                        nxt_d.code   = CODE_NOFUNDS;
                        nxt_d.to_pin = 1'b0;
                        nxt_d.amt    = '0;
                    end else begin
                        nxt_d.bal   = BAL_W'(bal_ext - amt_ext);
                        nxt_d.state = ST_HOLD;
                    end
                end else if (den_hit && (amt_sum <= LIM_S)) begin
                    nxt_d.amt = AMT_W'(amt_sum);
                end
            end
            ST_DEP: begin
                if (btn_enter) begin
                    if (dep_sum > CAP_S) begin
                        nxt_d.state  = ST_ERR;
                        nxt_d.code   = CODE_CAP;
                        nxt_d.to_pin = 1'b0;
                        nxt_d.amt    = '0;
                    end else begin
                        nxt_d.bal   = BAL_W'(dep_sum);
                        nxt_d.state = ST_HOLD;
                    end
                end else if (den_hit && (amt_sum <= LIM_S)) begin
                    nxt_d.amt = AMT_W'(amt_sum);
                end
            end
            ST_CHK: begin
                if (btn_enter) begin
                    if (nib_bad || (chk_sum > CAP_S)) begin
                        nxt_d.state  = ST_ERR;
                        nxt_d.code   = nib_bad ? CODE_BADAMT : CODE_CAP;
                        nxt_d.to_pin = 1'b0;
                        nxt_d.amt    = '0;
                    end else begin
                        nxt_d.bal   = BAL_W'(chk_sum);
                        nxt_d.amt   = AMT_W'(chk_val);
                        nxt_d.state = ST_HOLD;
                    end
                end
            end
            ST_NEWPIN: begin
                if (btn_enter) begin
                    if (sw == cur_q.pin) begin
                        nxt_d.state  = ST_ERR;
                        nxt_d.code   = CODE_SAMEPIN;
                        nxt_d.to_pin = 1'b0;
                    end else begin
                        nxt_d.pin   = sw;
                        nxt_d.state = ST_MENU;
                    end
                end
            end
            ST_HOLD: begin
                if (hold_done) nxt_d.state = ST_RESULT;
            end
            ST_ERR: begin
                if (btn_enter) begin
                    nxt_d.state = cur_q.to_pin ? ST_PIN : ST_MENU;
                    if (cur_q.to_pin) nxt_d.sel = '0;
                end
            end
            default: nxt_d.state = ST_PIN;
        endcase
    end

    // Display selection
    always_comb begin
        show_raw = 1'b1;
        raw_val  = DW'(sw);
        num_val  = cur_q.amt;
        case (cur_q.state)
            ST_MENU: raw_val = DW'(cur_q.sel) + DW'(1);
            ST_ERR: begin
                raw_val = DW'(cur_q.code);
                raw_val[DW-1 -: 4] = 4'hE;
            end
            ST_BAL, ST_RESULT: begin
                show_raw = 1'b0;
                num_val  = AMT_W'(cur_q.bal);
            end
            ST_WDR, ST_DEP, ST_HOLD: show_raw = 1'b0;
            default: ;
        endcase
        digits = show_raw ? raw_val : bcd_val;
        blink  = hold_lit;
        err    = (cur_q.state == ST_ERR);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q       <= '0;
            cur_q.state <= ST_PIN;
            cur_q.pin   <= PIN_INIT;
        end else begin
            cur_q <= nxt_d;
        end
    end
endmodule

// File: rtl/atm_ctrl_chk.sv
module atm_ctrl_chk
    import atm_pkg::*;
#(
    parameter int unsigned BAL_W   = 12,
    parameter int unsigned AMT_W   = 14,
    parameter int unsigned DIGITS  = 4,
    parameter int unsigned BAL_MAX = 1500,
    parameter int unsigned WDR_MAX = 500
) (
    input logic                clk,
    input logic                rst,
    input logic [7:0]          sw,
    input logic                btn_enter,
    input logic [4*DIGITS-1:0] digits,
    input logic                blink,
    input logic                err,
    input atm_state_e          state_q,
    input logic [AMT_W-1:0]    amt_q,
    input logic [BAL_W-1:0]    bal_q,
    input logic [7:0]          pin_q
);
    // R11
    err_code_chk: assert property (@(posedge clk) disable iff (rst)
        err |-> (digits[4*DIGITS-1 -: 4] == 4'hE));

    // R8
    blink_excl_chk: assert property (@(posedge clk) disable iff (rst)
        blink |-> !err);

    // R12
    bal_cap_chk: assert property (@(posedge clk) disable iff (rst)
        bal_q <= BAL_W'(BAL_MAX));

    // R12
    bal_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !btn_enter |=> $stable(bal_q));

    // R10
    pin_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_NEWPIN && btn_enter && sw == pin_q) |=> (err && $stable(pin_q)));

    // R5
    wdr_limit_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WDR && btn_enter && amt_q > AMT_W'(WDR_MAX))
        |=> (err && digits[3:0] == 4'd1));

    // R8
    hold_start_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_HOLD && $past(state_q) != ST_HOLD) |-> blink);
endmodule

bind atm_ctrl atm_ctrl_chk #(
    .BAL_W  (BAL_W),
    .AMT_W  (AMT_W),
    .DIGITS (DIGITS),
    .BAL_MAX(BAL_MAX),
    .WDR_MAX(WDR_MAX)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .sw       (sw),
    .btn_enter(btn_enter),
    .digits   (digits),
    .blink    (blink),
    .err      (err),
    .state_q  (cur_q.state),
    .amt_q    (cur_q.amt),
    .bal_q    (cur_q.bal),
    .pin_q    (cur_q.pin)
);

// File: tb/atm_ctrl_bench.sv
module atm_ctrl_bench;
    localparam int HOLD = 40;
    localparam int TOG  = 6;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  sw = 8'h00;
    logic        b_up = 0, b_dn = 0, b_lt = 0, b_rt = 0, b_en = 0;
    logic [15:0] digits;
    logic        blink, err;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    string cur_req = "R1";

    always #2 clk = ~clk;

    atm_ctrl #(.HOLD_CYCLES(HOLD), .TOGGLE_CYCLES(TOG)) u_atm_ctrl (
        .clk(clk), .rst(rst), .sw(sw),
        .btn_up(b_up), .btn_down(b_dn), .btn_left(b_lt), .btn_right(b_rt),
        .btn_enter(b_en), .digits(digits), .blink(blink), .err(err)
    );

    // Behavioural reference: mode names as integers
    // 0 pin,1 menu,2 bal,3 wdr,4 dep,5 chk,6 newpin,7 hold,8 result,9 error
    int m_mode, m_sel, m_amt, m_bal, m_pin, m_code, m_k;
    bit m_back;

    function automatic logic [15:0] to_bcd(int v);
        return {4'(v / 1000 % 10), 4'(v / 100 % 10), 4'(v / 10 % 10), 4'(v % 10)};
    endfunction

    function automatic logic [15:0] exp_digits();
        case (m_mode)
            1: return 16'(m_sel + 1);
            2, 8: return to_bcd(m_bal);
            3, 4, 7: return to_bcd(m_amt);
            9: return {4'hE, 8'h00, 4'(m_code)};
            default: return {8'h00, sw};
        endcase
    endfunction

    task automatic fail_err(int code, bit back);
        m_mode = 9; m_code = code; m_back = back; m_amt = 0;
    endtask

    always @(posedge clk) begin
        int den, hi, lo;
        if (rst) begin
            m_mode = 0; m_sel = 0; m_amt = 0; m_bal = 0; m_pin = 'h5A;
            m_code = 0; m_k = 0; m_back = 0;
        end else begin
            den = b_up ? 10 : b_rt ? 20 : b_dn ? 50 : 100;
            case (m_mode)
                0: if (b_en) begin
                       if (int'(sw) == m_pin) begin m_mode = 1; m_sel = 0; end
                       else fail_err(5, 1);
                   end
                1: if (b_en) begin m_amt = 0; m_mode = (m_sel == 4) ? 6 : m_sel + 2; end
                   else if (b_up || b_rt) m_sel = (m_sel + 1) % 5;
                   else if (b_dn || b_lt) m_sel = (m_sel + 4) % 5;
                2, 8: if (b_en) m_mode = 1;
                3: if (b_en) begin
                       if (m_amt % 20 != 0 || m_amt > 500) fail_err(1, 0);
                       else if (m_amt > m_bal) fail_err(2, 0);
                       else begin m_bal -= m_amt; m_mode = 7; m_k = 0; end
                   end else if ((b_up || b_rt || b_dn || b_lt) && m_amt + den <= 9999) m_amt += den;
                4: if (b_en) begin
                       if (m_bal + m_amt > 1500) fail_err(3, 0);
                       else begin m_bal += m_amt; m_mode = 7; m_k = 0; end
                   end else if ((b_up || b_rt || b_dn || b_lt) && m_amt + den <= 9999) m_amt += den;
                5: if (b_en) begin
                       hi = int'(sw[7:4]); lo = int'(sw[3:0]);
                       if (hi > 9 || lo > 9) fail_err(1, 0);
                       else if (m_bal + hi * 10 + lo > 1500) fail_err(3, 0);
                       else begin m_amt = hi * 10 + lo; m_bal += m_amt; m_mode = 7; m_k = 0; end
                   end
                6: if (b_en) begin
                       if (int'(sw) == m_pin) fail_err(4, 0);
                       else begin m_pin = int'(sw); m_mode = 1; end
                   end
                7: if (m_k == HOLD - 1) m_mode = 8; else m_k++;
                default: if (b_en) begin
                       m_mode = m_back ? 0 : 1;
                       if (m_back) m_sel = 0;
                   end
            endcase
        end
    end

    task automatic report(string req, string what, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the reference, away from the edge
    always @(negedge clk) begin
        #1;
        if (!rst && !finished) begin
            report(cur_req, "digits", digits, exp_digits());
            report(cur_req, "blink", 16'(blink), 16'((m_mode == 7) && ((m_k / TOG) % 2 == 0)));
            report(cur_req, "err", 16'(err), 16'(m_mode == 9));
        end
    end

    task automatic press(int which);
        @(negedge clk);
        case (which)
            0: b_up = 1; 1: b_dn = 1; 2: b_lt = 1; 3: b_rt = 1; default: b_en = 1;
        endcase
        @(negedge clk);
        b_up = 0; b_dn = 0; b_lt = 0; b_rt = 0; b_en = 0;
    endtask

    localparam int UP = 0, DN = 1, LT = 2, RT = 3, EN = 4;

    task automatic expect_disp(string req, logic [15:0] exp);
        #2;
        report(req, "display", digits, exp);
    endtask

    task automatic set_sw(logic [7:0] v);
        @(negedge clk);
        sw = v;
    endtask

    task automatic finish_run();
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL R8 watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset state
        cur_req = "R1";
        expect_disp("R1", 16'h0000);
        report("R1", "err", 16'(err), 16'h0);
        report("R1", "blink", 16'(blink), 16'h0);
        set_sw(8'h11);
        expect_disp("R1", 16'h0011);

        // R2 wrong then right PIN
        cur_req = "R2";
        press(EN); expect_disp("R2", 16'hE005);
        report("R11", "err", 16'(err), 16'h1);
        press(EN); expect_disp("R2", 16'h0011);
        set_sw(8'h5A);
        press(EN); expect_disp("R2", 16'h0001);

        // R3 menu navigation with wrap
        cur_req = "R3";
        press(DN); expect_disp("R3", 16'h0005);
        press(UP); expect_disp("R3", 16'h0001);
        press(RT); press(RT); expect_disp("R3", 16'h0003);
        press(LT); expect_disp("R3", 16'h0002);

        // R5 insufficient funds
        cur_req = "R5";
        press(EN); press(RT); expect_disp("R4", 16'h0020);
        press(EN); expect_disp("R5", 16'hE002);
        press(EN); expect_disp("R11", 16'h0002);

        // R6 deposit 360, R8 hold with ignored enter
        cur_req = "R8";
        press(RT); press(EN);
        press(LT); press(LT); press(LT); press(DN); press(UP);
        expect_disp("R4", 16'h0360);
        press(EN); expect_disp("R6", 16'h0360);
        report("R8", "blink start", 16'(blink), 16'h1);
        repeat (10) @(negedge clk);
        press(EN);
        repeat (HOLD) @(negedge clk);
        expect_disp("R8", 16'h0360);
        report("R8", "blink after", 16'(blink), 16'h0);
        press(EN); expect_disp("R8", 16'h0003);

        // R5 invalid amounts, then a valid withdrawal
        cur_req = "R5";
        press(LT); press(EN); press(UP); press(EN);
        expect_disp("R5", 16'hE001);
        press(EN); press(EN);
        repeat (6) press(LT);
        press(EN); expect_disp("R5", 16'hE001);
        press(EN); press(EN);
        press(LT); press(RT); press(RT); press(EN);
        repeat (HOLD + 2) @(negedge clk);
        expect_disp("R5", 16'h0220);
        press(EN);

        // R6 cap rejection, R9 balance inquiry
        cur_req = "R6";
        press(RT); press(EN);
        repeat (13) press(LT);
        press(EN); expect_disp("R6", 16'hE003);
        press(EN);
        cur_req = "R9";
        press(LT); press(LT); press(EN); expect_disp("R9", 16'h0220);
        press(EN); expect_disp("R9", 16'h0001);

        // R7 check deposit
        cur_req = "R7";
        press(RT); press(RT); press(RT); press(EN);
        set_sw(8'h9A); expect_disp("R7", 16'h009A);
        press(EN); expect_disp("R7", 16'hE001);
        press(EN); press(EN);
        set_sw(8'h75); press(EN);
        repeat (HOLD + 2) @(negedge clk);
        expect_disp("R7", 16'h0295);
        press(EN);

        // R4 amount ceiling
        cur_req = "R4";
        press(LT); press(EN);
        repeat (99) press(LT);
        expect_disp("R4", 16'h9900);
        press(LT); expect_disp("R4", 16'h9900);
        press(DN); expect_disp("R4", 16'h9950);
        press(DN); expect_disp("R4", 16'h9950);
        press(UP); expect_disp("R4", 16'h9960);
        press(EN); expect_disp("R6", 16'hE003);
        press(EN);

        // R10 PIN change
        cur_req = "R10";
        press(RT); press(RT); press(EN);
        set_sw(8'h5A); press(EN); expect_disp("R10", 16'hE004);
        press(EN); press(EN);
        set_sw(8'h3C); press(EN); expect_disp("R10", 16'h0005);
        press(EN); press(EN); expect_disp("R10", 16'hE004);
        press(EN);

        // R12 balance kept at 295 after all rejections
        cur_req = "R12";
        press(UP); press(EN); expect_disp("R12", 16'h0295);

        // R1 reset mid-session
        cur_req = "R1";
        @(negedge clk); rst = 1;
        @(negedge clk); @(negedge clk); rst = 0;
        set_sw(8'h00);
        expect_disp("R1", 16'h0000);
        report("R1", "err", 16'(err), 16'h0);
        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule